// File: doc/BRIEF.md
# Fixed-Point Flag Generator

This block sits beside a fixed-point execution pipe. It does not compute anything itself. It is given the operands and the 64-bit result of an operation that has just completed. From these it derives the carry pair (CA, CA32), the overflow pair (OV, OV32), the sticky summary-overflow bit SO, and the four-bit condition field CR0, and it holds them in registers. The operation's control bits steer how the flags are derived:

- an invert flag for operand A;
- a selector telling it whether to use operand B or an immediate;
- an add-type flag;
- enables for carry, overflow and record;
- an optional divide-overflow indication;
- per-flag "already produced" markers, for operations that compute their own carry.

All flag registers change only on a clock edge where the operation strobe `valid_i` is high, or where a direct XER write is presented. The XER write is the only path, other than reset, that can lower SO. The reset input is asynchronous and active low. Inside the block its release is synchronised over two clock edges.

Top module: `fxflag_unit`

## Requirements
- R1: While reset is held, and until the first strobe or write after reset, all of ca_o, ca32_o, ov_o, ov32_o, so_o and cr0_o read zero.
- R2: The first input is op_a_i, or its bitwise inverse when invert_a_i is 1. The second input is imm_i when imm_valid_i is 1, otherwise op_b_i. A second input exists only when b_valid_i or imm_valid_i is 1.
- R3: On a strobe with carry_en_i set and ca_done_i clear, CA becomes 1 exactly when some input is unsigned-greater than result_i.
- R4: On a strobe with carry_en_i set and ca32_done_i clear, CA32 depends on is_add_i. If is_add_i is 1, CA32 is the XOR of bit 32 of result_i, bit 32 of the first input, and bit 32 of the second input (taken as 0 if there is no second input). Otherwise CA32 is 1 exactly when the low 32 bits of some input are unsigned-greater than the low 32 bits of result_i.
- R5: When ca_done_i (or ca32_done_i) is set, that flag takes ca_val_i (or ca32_val_i) whatever carry_en_i is. When neither the done marker nor carry_en_i is set, the flag keeps its value.
- R6: On a strobe with ov_en_i set, no divide indication, and two inputs, OV is 1 exactly when both inputs share bit 63 and result bit 63 differs from it. OV32 applies the same rule to bit 31. With a single input, OV and OV32 are unchanged.
- R7: On a strobe with div_ov_valid_i set, OV and OV32 both take div_ov_i, whatever ov_en_i is. If neither ov_en_i nor div_ov_valid_i is set, OV and OV32 keep their values.
- R8: Whenever OV and OV32 are updated, SO becomes SO OR the new OV. SO is lowered only by reset or by an XER write.
- R9: On a strobe with rc_en_i set, cr0_o becomes {negative, positive, zero, SO}. Bit 3 is negative, bit 0 is SO. The first three are judged on result_i as a signed 64-bit value. SO is the value after this operation's update. Without rc_en_i, cr0_o is held.
- R10: When xer_wr_i is 1, the five XER flags load xer_wdata_i ([4]=SO, [3]=OV, [2]=OV32, [1]=CA, [0]=CA32) on that edge. A strobe on the same edge is ignored entirely, including CR0.
- R11: Without valid_i or xer_wr_i, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation-complete strobe |
| op_a_i | input | DATA_W | Operand A |
| op_b_i | input | DATA_W | Operand B |
| b_valid_i | input | 1 | Operand B is present |
| imm_i | input | DATA_W | Immediate value |
| imm_valid_i | input | 1 | Immediate replaces operand B |
| invert_a_i | input | 1 | Use inverted operand A |
| is_add_i | input | 1 | Add-type operation (CA32 rule) |
| carry_en_i | input | 1 | Update CA/CA32 |
| ov_en_i | input | 1 | Update OV/OV32 by sign rule |
| rc_en_i | input | 1 | Update CR0 |
| div_ov_valid_i | input | 1 | Divide-overflow indication present |
| div_ov_i | input | 1 | Divide-overflow value |
| ca_done_i | input | 1 | Operation produced CA itself |
| ca_val_i | input | 1 | Operation's CA value |
| ca32_done_i | input | 1 | Operation produced CA32 itself |
| ca32_val_i | input | 1 | Operation's CA32 value |
| result_i | input | DATA_W | Operation result |
| xer_wr_i | input | 1 | Direct XER flag write |
| xer_wdata_i | input | 5 | Written flags {SO,OV,OV32,CA,CA32} |
| ca_o | output | 1 | Carry |
| ca32_o | output | 1 | 32-bit carry |
| ov_o | output | 1 | Overflow |
| ov32_o | output | 1 | 32-bit overflow |
| so_o | output | 1 | Sticky summary overflow |
| cr0_o | output | 4 | Condition field {neg,pos,zero,SO} |

## Verification
The bench builds the block with its default DATA_W of 64, so the low-half width is 32. This places the CA32 add tap at bit 32 and the OV32 sign at bit 31, exactly where the requirements state them. With these values, operands such as 0x1_0000_0000 and 0x7FFF_FFFF can separate the 64-bit rules from the 32-bit rules. Directed steps cover the following:

- inversion of operand A and immediate substitution;
- single-input operations;
- done markers overriding the carry enable;
- the divide indication overriding the sign rule;
- SO persisting through later non-overflowing operations until an XER write;
- a write and a strobe arriving together.

A long seeded stream of mixed operations is then compared each clock against a behavioural model.

// File: rtl/fxflag_pkg.sv
package fxflag_pkg;
  // XER flag set; packed order matches the write-data bit positions
  typedef struct packed {
    logic so;
    logic ov;
    logic ov32;
    logic ca;
    logic ca32;
  } xer_flags_t;

  // Condition field; bit 3 down to bit 0
  typedef struct packed {
    logic neg;
    logic pos;
    logic zero;
    logic so;
  } cr_field_t;
endpackage

// File: rtl/fxflag_carry.sv
module fxflag_carry #(
  parameter int DATA_W = 64,
  parameter int LOW_W  = DATA_W / 2
) (
  input  logic [DATA_W-1:0] in_a_i,
  input  logic [DATA_W-1:0] in_b_i,
  input  logic              two_in_i,
  input  logic              is_add_i,
  input  logic [DATA_W-1:0] res_i,
  output logic              ca_o,
  output logic              ca32_o
);
  logic [LOW_W-1:0] a_lo, b_lo, r_lo;
  logic             b_tap;
  logic             ca32_cmp;

  assign a_lo  = in_a_i[LOW_W-1:0];
  assign b_lo  = in_b_i[LOW_W-1:0];
  assign r_lo  = res_i[LOW_W-1:0];
  assign b_tap = two_in_i & in_b_i[LOW_W];

  always_comb begin
    ca_o     = (in_a_i > res_i) | (two_in_i & (in_b_i > res_i));
    ca32_cmp = (a_lo > r_lo) | (two_in_i & (b_lo > r_lo));
    if (is_add_i) begin
      ca32_o = res_i[LOW_W] ^ in_a_i[LOW_W] ^ b_tap;
    end else begin
      ca32_o = ca32_cmp;
    end
  end
endmodule

// File: rtl/fxflag_ovf.sv
module fxflag_ovf #(
  parameter int DATA_W = 64,
  parameter int LOW_W  = DATA_W / 2
) (
  input  logic [DATA_W-1:0] in_a_i,
  input  logic [DATA_W-1:0] in_b_i,
  input  logic              two_in_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              ov_en_i,
  input  logic              div_valid_i,
  input  logic              div_ov_i,
  output logic              upd_o,
  output logic              ov_o,
  output logic              ov32_o
);
  localparam int MSB   = DATA_W - 1;
  localparam int MSB32 = LOW_W - 1;

  logic sign_ov, sign_ov32;

  always_comb begin
    sign_ov   = (in_a_i[MSB] == in_b_i[MSB]) && (res_i[MSB] != in_a_i[MSB]);
    sign_ov32 = (in_a_i[MSB32] == in_b_i[MSB32]) && (res_i[MSB32] != in_a_i[MSB32]);
    upd_o     = div_valid_i | (ov_en_i & two_in_i);
    if (div_valid_i) begin
      ov_o   = div_ov_i;
      ov32_o = div_ov_i;
    end else begin
      ov_o   = sign_ov;
      ov32_o = sign_ov32;
    end
  end
endmodule

// File: rtl/fxflag_cr0.sv
module fxflag_cr0
  import fxflag_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              so_i,
  output cr_field_t         cr_o
);
  always_comb begin
    cr_o.neg  = res_i[DATA_W-1];
    cr_o.zero = ~|res_i;
    cr_o.pos  = ~res_i[DATA_W-1] & (|res_i);
    cr_o.so   = so_i;
  end
endmodule

// File: rtl/fxflag_unit.sv
module fxflag_unit
  import fxflag_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              b_valid_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              imm_valid_i,
  input  logic              invert_a_i,
  input  logic              is_add_i,
  input  logic              carry_en_i,
  input  logic              ov_en_i,
  input  logic              rc_en_i,
  input  logic              div_ov_valid_i,
  input  logic              div_ov_i,
  input  logic              ca_done_i,
  input  logic              ca_val_i,
  input  logic              ca32_done_i,
  input  logic              ca32_val_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              xer_wr_i,
  input  logic [4:0]        xer_wdata_i,
  output logic              ca_o,
  output logic              ca32_o,
  output logic              ov_o,
  output logic              ov32_o,
  output logic              so_o,
  output logic [3:0]        cr0_o
);
  localparam int LOW_W = DATA_W / 2;

  // reset: asynchronous assert, two-stage synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // operand selection
  logic [DATA_W-1:0] in_a, in_b;
  logic              two_in;

  assign in_a   = invert_a_i ? ~op_a_i : op_a_i;
  assign in_b   = imm_valid_i ? imm_i : op_b_i;
  assign two_in = b_valid_i | imm_valid_i;

  logic ca_c, ca32_c, ov_upd, ov_c, ov32_c;

  fxflag_carry #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_carry (
    .in_a_i   (in_a),
    .in_b_i   (in_b),
    .two_in_i (two_in),
    .is_add_i (is_add_i),
    .res_i    (result_i),
    .ca_o     (ca_c),
    .ca32_o   (ca32_c)
  );

  fxflag_ovf #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_ovf (
    .in_a_i      (in_a),
    .in_b_i      (in_b),
    .two_in_i    (two_in),
    .res_i       (result_i),
    .ov_en_i     (ov_en_i),
    .div_valid_i (div_ov_valid_i),
    .div_ov_i    (div_ov_i),
    .upd_o       (ov_upd),
    .ov_o        (ov_c),
    .ov32_o      (ov32_c)
  );

  xer_flags_t xer_q, xer_d;
  cr_field_t  cr_q, cr_d, cr_c;
  logic       xer_en, cr_en;

  fxflag_cr0 #(.DATA_W(DATA_W)) u_cr0 (
    .res_i (result_i),
    .so_i  (xer_d.so),
    .cr_o  (cr_c)
  );

  // next state
  always_comb begin
    xer_d  = xer_q;
    cr_d   = cr_q;
    xer_en = 1'b0;
    cr_en  = 1'b0;
    if (xer_wr_i) begin
      xer_d  = xer_flags_t'(xer_wdata_i);
      xer_en = 1'b1;
    end else if (valid_i) begin
      xer_en = 1'b1;
      if (ca_done_i)        xer_d.ca = ca_val_i;
      else if (carry_en_i)  xer_d.ca = ca_c;
      if (ca32_done_i)      xer_d.ca32 = ca32_val_i;
      else if (carry_en_i)  xer_d.ca32 = ca32_c;
      if (ov_upd) begin
        xer_d.ov   = ov_c;
        xer_d.ov32 = ov32_c;
        xer_d.so   = xer_q.so | ov_c;
      end
      if (rc_en_i) begin
        cr_d  = cr_c;
        cr_en = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      xer_q <= '0;
    end else if (xer_en) begin
      xer_q <= xer_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cr_q <= '0;
    end else if (cr_en) begin
      cr_q <= cr_d;
    end
  end

  assign ca_o   = xer_q.ca;
  assign ca32_o = xer_q.ca32;
  assign ov_o   = xer_q.ov;
  assign ov32_o = xer_q.ov32;
  assign so_o   = xer_q.so;
  assign cr0_o  = cr_q;
endmodule

// File: rtl/fxflag_unit_chk.sv
module fxflag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       valid_i,
  input logic       carry_en_i,
  input logic       ov_en_i,
  input logic       rc_en_i,
  input logic       div_ov_valid_i,
  input logic       div_ov_i,
  input logic       ca_done_i,
  input logic       ca_val_i,
  input logic       ca32_done_i,
  input logic       xer_wr_i,
  input logic [4:0] xer_wdata_i,
  input logic       ca_o,
  input logic       ca32_o,
  input logic       ov_o,
  input logic       ov32_o,
  input logic       so_o,
  input logic [3:0] cr0_o
);
  // R8: SO never drops except through an XER write
  a_r8_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (so_o && !xer_wr_i) |=> so_o);

  // R7: divide indication drives both overflow bits
  a_r7_div_override: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !xer_wr_i && div_ov_valid_i) |=> (ov_o == $past(div_ov_i)) && (ov32_o == $past(div_ov_i)));

  // R5: an operation-produced CA wins
  a_r5_done_ca: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !xer_wr_i && ca_done_i) |=> (ca_o == $past(ca_val_i)));

  // R5: no enable and no done marker leaves carries alone
  a_r5_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !xer_wr_i && !carry_en_i && !ca_done_i && !ca32_done_i) |=> ($stable(ca_o) && $stable(ca32_o)));

  // R7: overflow untouched when neither enable nor divide indication
  a_r7_ov_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !xer_wr_i && !ov_en_i && !div_ov_valid_i) |=> ($stable(ov_o) && $stable(ov32_o)));

  // R9: recorded field has exactly one relation bit and carries current SO
  a_r9_cr0_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !xer_wr_i && rc_en_i) |=> ($countones(cr0_o[3:1]) == 1) && (cr0_o[0] == so_o));

  // R10: write loads the flags and leaves CR0 alone
  a_r10_xer_write: assert property (@(posedge clk) disable iff (!rst_n)
    xer_wr_i |=> ({so_o, ov_o, ov32_o, ca_o, ca32_o} == $past(xer_wdata_i)) && $stable(cr0_o));

  // R11: idle cycles change nothing
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !xer_wr_i) |=> ($stable({so_o, ov_o, ov32_o, ca_o, ca32_o}) && $stable(cr0_o)));
endmodule

bind fxflag_unit fxflag_unit_chk u_fxflag_unit_chk (
  .clk            (clk),
  .rst_n          (rst_int_n),
  .valid_i        (valid_i),
  .carry_en_i     (carry_en_i),
  .ov_en_i        (ov_en_i),
  .rc_en_i        (rc_en_i),
  .div_ov_valid_i (div_ov_valid_i),
  .div_ov_i       (div_ov_i),
  .ca_done_i      (ca_done_i),
  .ca_val_i       (ca_val_i),
  .ca32_done_i    (ca32_done_i),
  .xer_wr_i       (xer_wr_i),
  .xer_wdata_i    (xer_wdata_i),
  .ca_o           (ca_o),
  .ca32_o         (ca32_o),
  .ov_o           (ov_o),
  .ov32_o         (ov32_o),
  .so_o           (so_o),
  .cr0_o          (cr0_o)
);

// File: tb/test_fxflag_unit.sv
module test_fxflag_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        valid_i = 0, b_valid_i = 0, imm_valid_i = 0, invert_a_i = 0, is_add_i = 0;
  logic        carry_en_i = 0, ov_en_i = 0, rc_en_i = 0, div_ov_valid_i = 0, div_ov_i = 0;
  logic        ca_done_i = 0, ca_val_i = 0, ca32_done_i = 0, ca32_val_i = 0, xer_wr_i = 0;
  logic [63:0] op_a_i = 0, op_b_i = 0, imm_i = 0, result_i = 0;
  logic [4:0]  xer_wdata_i = 0;
  logic        ca_o, ca32_o, ov_o, ov32_o, so_o;
  logic [3:0]  cr0_o;

  fxflag_unit i_fxflag_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .b_valid_i(b_valid_i), .imm_i(imm_i), .imm_valid_i(imm_valid_i), .invert_a_i(invert_a_i),
    .is_add_i(is_add_i), .carry_en_i(carry_en_i), .ov_en_i(ov_en_i), .rc_en_i(rc_en_i),
    .div_ov_valid_i(div_ov_valid_i), .div_ov_i(div_ov_i), .ca_done_i(ca_done_i),
    .ca_val_i(ca_val_i), .ca32_done_i(ca32_done_i), .ca32_val_i(ca32_val_i),
    .result_i(result_i), .xer_wr_i(xer_wr_i), .xer_wdata_i(xer_wdata_i),
    .ca_o(ca_o), .ca32_o(ca32_o), .ov_o(ov_o), .ov32_o(ov32_o), .so_o(so_o), .cr0_o(cr0_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural model state
  bit m_ca, m_ca32, m_ov, m_ov32, m_so;
  bit [3:0] m_cr;

  task automatic check(string tag, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string tag);
    check({tag, " R3"}, "ca", {3'b0, ca_o}, {3'b0, m_ca});
    check({tag, " R4"}, "ca32", {3'b0, ca32_o}, {3'b0, m_ca32});
    check({tag, " R6"}, "ov", {3'b0, ov_o}, {3'b0, m_ov});
    check({tag, " R6"}, "ov32", {3'b0, ov32_o}, {3'b0, m_ov32});
    check({tag, " R8"}, "so", {3'b0, so_o}, {3'b0, m_so});
    check({tag, " R9"}, "cr0", cr0_o, m_cr);
  endtask

  function automatic void model_edge();
    longint unsigned a, b, r, lo;
    longint sr;
    bit two, nov;
    lo = 64'hFFFF_FFFF;
    if (xer_wr_i) begin
      {m_so, m_ov, m_ov32, m_ca, m_ca32} = xer_wdata_i;
      return;
    end
    if (!valid_i) return;
    a = invert_a_i ? ~op_a_i : op_a_i;
    b = imm_valid_i ? imm_i : op_b_i;
    two = b_valid_i || imm_valid_i;
    r = result_i;
    if (ca_done_i) m_ca = ca_val_i;
    else if (carry_en_i) m_ca = (a > r) || (two && (b > r));
    if (ca32_done_i) m_ca32 = ca32_val_i;
    else if (carry_en_i) begin
      if (is_add_i) m_ca32 = r[32] ^ a[32] ^ (two ? b[32] : 1'b0);
      else m_ca32 = ((a & lo) > (r & lo)) || (two && ((b & lo) > (r & lo)));
    end
    if (div_ov_valid_i) begin
      m_ov = div_ov_i; m_ov32 = div_ov_i;
      m_so = m_so | div_ov_i;
    end else if (ov_en_i && two) begin
      nov = (a[63] == b[63]) && (r[63] != a[63]);
      m_ov = nov;
      m_ov32 = (a[31] == b[31]) && (r[31] != a[31]);
      m_so = m_so | nov;
    end
    if (rc_en_i) begin
      sr = signed'(r);
      m_cr = {sr < 0, sr > 0, sr == 0, m_so};
    end
  endfunction

  task automatic clear_ctl();
    valid_i = 0; b_valid_i = 0; imm_valid_i = 0; invert_a_i = 0; is_add_i = 0;
    carry_en_i = 0; ov_en_i = 0; rc_en_i = 0; div_ov_valid_i = 0; div_ov_i = 0;
    ca_done_i = 0; ca_val_i = 0; ca32_done_i = 0; ca32_val_i = 0; xer_wr_i = 0;
  endtask

  // inputs are set at a negative edge, the model follows, compare at next negative edge
  task automatic step(string tag);
    model_edge();
    @(negedge clk);
    compare_all(tag);
    clear_ctl();
  endtask

  task automatic op2(logic [63:0] a, logic [63:0] b, logic [63:0] r, bit add);
    valid_i = 1; b_valid_i = 1; op_a_i = a; op_b_i = b; result_i = r; is_add_i = add;
    carry_en_i = 1; ov_en_i = 1; rc_en_i = 1;
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_ca = 0; m_ca32 = 0; m_ov = 0; m_ov32 = 0; m_so = 0; m_cr = 0;
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    compare_all("R1 after reset");

    // R3 R4 R6 R9: plain add without overflow
    op2(64'd5, 64'd7, 64'd12, 1); step("R3 add small");
    // R3: wrapping add sets CA; R9 positive
    op2(64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd1, 1); step("R3 add wrap");
    // R4: carry across bit 32 only
    op2(64'hFFFF_FFFF, 64'd1, 64'h1_0000_0000, 1); step("R4 add bit32");
    // R4: non-add low-half compare
    op2(64'h0000_0001_0000_0005, 64'd0, 64'h0000_0002_0000_0003, 0); step("R4 compare low");
    // R6 R8: positive overflow, SO sets
    op2(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_0000_0000, 1); step("R6 ovf pos");
    // R8: SO stays after a clean op; R9 zero
    op2(64'd0, 64'd0, 64'd0, 1); step("R8 so sticky");
    // R6: 32-bit overflow only
    op2(64'h7FFF_FFFF, 64'd1, 64'h8000_0000, 1); step("R6 ov32 only");
    // R2: inverted A
    op2(64'd3, 64'd9, 64'd5, 1); invert_a_i = 1; step("R2 invert");
    // R2: immediate replaces B
    op2(64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd4, 1); imm_valid_i = 1; imm_i = 64'd3; step("R2 immediate");
    // R6: single input, OV untouched, carry uses A only
    op2(64'h8000_0000_0000_0000, 64'd0, 64'd1, 0); b_valid_i = 0; step("R6 single input");
    // R5: done markers override, carry enable off
    op2(64'd9, 64'd9, 64'd0, 0); carry_en_i = 0; ca_done_i = 1; ca_val_i = 0;
    ca32_done_i = 1; ca32_val_i = 1; step("R5 done");
    // R5: no enable keeps CA
    op2(64'hFFFF, 64'hFFFF, 64'd1, 0); carry_en_i = 0; step("R5 hold");
    // R7: divide indication beats sign rule, OE off
    op2(64'd4, 64'd2, 64'd2, 0); ov_en_i = 0; div_ov_valid_i = 1; div_ov_i = 1; step("R7 div set");
    op2(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_0000_0000, 0); div_ov_valid_i = 1; div_ov_i = 0; step("R7 div clear");
    // R7: neither enable nor divide
    op2(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_0000_0000, 0); ov_en_i = 0; step("R7 ov hold");
    // R10: write clears SO; strobe on the same edge ignored
    op2(64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd1, 1); xer_wr_i = 1; xer_wdata_i = 5'b00110; step("R10 write");
    // R11: idle cycles
    step("R11 idle"); step("R11 idle");
    // R9: negative, R6 negative overflow
    op2(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0, 1); step("R6 ovf neg");
    op2(64'd1, 64'd2, 64'hFFFF_FFFF_FFFF_FFFD, 0); step("R9 negative");

    // mixed stream
    void'($urandom(32'd77));
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 7 == 0) a = 64'h7FFF_FFFF_FFFF_FFF0 + 64'($urandom % 32);
      if (i % 11 == 0) b = 64'hFFFF_FFFF + 64'($urandom % 4);
      op_a_i = a; op_b_i = b; imm_i = {32'b0, $urandom};
      valid_i = ($urandom % 5) != 0;
      b_valid_i = $urandom; imm_valid_i = ($urandom % 4) == 0;
      invert_a_i = ($urandom % 4) == 0; is_add_i = $urandom;
      carry_en_i = $urandom; ov_en_i = $urandom; rc_en_i = $urandom;
      div_ov_valid_i = ($urandom % 8) == 0; div_ov_i = $urandom;
      ca_done_i = ($urandom % 8) == 0; ca_val_i = $urandom;
      ca32_done_i = ($urandom % 8) == 0; ca32_val_i = $urandom;
      xer_wr_i = ($urandom % 16) == 0; xer_wdata_i = 5'($urandom);
      case ($urandom % 4)
        0: result_i = (invert_a_i ? ~a : a) + (imm_valid_i ? imm_i : b);
        1: result_i = 64'd0;
        default: result_i = {$urandom, $urandom};
      endcase
      step("R3 R4 R6 R8 R9 mixed");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule